// File: doc/BRIEF.md
# Load Front End with Console Receive Window

This block sits between a 64-bit core's load unit and its data memory. Each cycle the core may present one read request: an address and a size code for 1, 2, 4 or 8 bytes. The block first decides whether the access stays inside one 16-byte block. Natural alignment is not demanded, so any start address is legal as long as the last byte falls in the same block as the first. A crossing access raises a fault in the same cycle and nothing else happens.

Legal requests to two fixed addresses never reach memory. One of them returns a word built from the console receiver's byte and its valid flag, and pulses a strobe that tells the receiver to drop that flag. The other returns a fixed status constant. All other legal requests are issued to the memory port. The memory answers one cycle later, and the block returns that data with its eight bytes in reverse order. The console words are returned as they are built and are never reversed. Every answer appears one cycle after its request, qualified by a valid output.

Top module: `ld_front`

## Requirements
- R1: An access with size code 0, 1, 2 or 3 (1, 2, 4 or 8 bytes) at address A is legal exactly when A/16 and (A+bytes-1)/16, both rounded down, are equal. A 1-byte access is never a fault, and the test does not wrap at the top of the address space.
- R2: `fault` is high in the same cycle as a crossing request. In that cycle `mem_rd_en` and `rx_clear` stay low, and in the next cycle `rsp_valid` stays low.
- R3: A legal request to any address other than the two console addresses drives `mem_rd_en` high, with `mem_addr` equal to `req_addr`, in the request cycle. In the following cycle `rsp_valid` is high.
- R4: The memory answer is returned with its bytes reversed: byte k of `rsp_data` (bits 8k+7..8k) equals byte 7-k of `mem_rdata`, sampled one cycle after `mem_rd_en`.
- R5: A legal read of 0x7F000000 returns `rx_byte` in bits 31..24 and `rx_valid` in bit 23, both sampled in the request cycle, with all other bits zero and no byte reversal. It does not drive `mem_rd_en`.
- R6: `rx_clear` is high in the request cycle of a legal read of 0x7F000000, and at no other time.
- R7: A legal read of 0x7F000004 returns 0x000000000004FFFF, unreversed, and does not drive `mem_rd_en`.
- R8: Only an exact 64-bit match selects a console word. Neighbouring addresses such as 0x7F000001 and 0x7F000008 go to memory.
- R9: After reset, and in every cycle that follows no legal request, `rsp_valid` is low and `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present this cycle |
| req_addr | input | 64 | Byte address of the read |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| rx_byte | input | 8 | Console receive byte |
| rx_valid | input | 1 | Console receive byte is valid |
| mem_rdata | input | 64 | Memory read data, one cycle after `mem_rd_en` |
| fault | output | 1 | Request crosses a 16-byte block (combinational) |
| rx_clear | output | 1 | Clear the console receive-valid flag (combinational) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 64 | Memory read address |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |

## Verification
On every cycle, the assertions check that a fault blocks both the memory strobe and the clear strobe, that a 1-byte access never faults, and that a response appears exactly one cycle after each legal request and never after any other. They also check that console reads never touch memory, that a clear strobe is followed by a word carrying the sampled byte and flag, and that an idle response bus is zero. The exact block-crossing boundaries, including the top-of-address case, cannot be covered by properties this general. The same holds for the byte order after reversal, the neighbours of the console addresses and back-to-back mixes of memory and console reads. Only the bench's scenarios show those.

// File: rtl/ld_front_pkg.sv
// Package: shared constants and types for the load front end.
// Assumes 64-bit addresses and data; console addresses are fixed.
package ld_front_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } ld_size_e;

    localparam logic [63:0] CON_DATA_ADDR = 64'h0000_0000_7F00_0000;
    localparam logic [63:0] CON_STAT_ADDR = 64'h0000_0000_7F00_0004;
    localparam logic [63:0] CON_STAT_WORD = 64'h0000_0000_0004_FFFF;
    localparam int          CON_BYTE_LSB  = 24;
    localparam int          CON_FLAG_BIT  = 23;
endpackage

// File: rtl/ld_block_check.sv
// Module: ld_block_check
// Flags an access whose last byte lies in a different 2**BLOCK_LG2-byte
// block than its first byte. Only the low address bits are summed, so
// the test cannot wrap at the top of the address space.
// Assumes BLOCK_LG2 >= 3 so that an 8-byte access fits in a block.
module ld_block_check #(
    parameter int ADDR_W    = 64,
    parameter int BLOCK_LG2 = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              crosses
);
    localparam int OFF_W = BLOCK_LG2 + 1;

    logic [OFF_W-1:0] span_m1;
    logic [OFF_W-1:0] last_off;

    // Offset of the last byte relative to the block start; a carry out means a crossing.
    always_comb begin
        span_m1  = (OFF_W'(1) << size) - OFF_W'(1);
        last_off = {1'b0, addr[BLOCK_LG2-1:0]} + span_m1;
        crosses  = last_off[OFF_W-1];
    end
endmodule

// File: rtl/ld_byte_rev.sv
// Module: ld_byte_rev
// Reverses the byte order of a DATA_W-bit word. Pure wiring.
// Assumes DATA_W is a multiple of 8.
module ld_byte_rev #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign dout[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
    end
endmodule

// File: rtl/ld_resp_stage.sv
// Module: ld_resp_stage
// Holds one response slot: records whether the answer comes from memory
// or from a console word captured at the request edge, then presents it
// one cycle later. Data is forced to zero while no response is valid.
// Assumes memory data arrives exactly one cycle after the read strobe.
module ld_resp_stage #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              from_mem,
    input  logic [DATA_W-1:0] local_word,
    input  logic [DATA_W-1:0] mem_word_rev,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic              valid_q;
    logic              mem_q;
    logic [DATA_W-1:0] local_q;

    // Capture the kind of the accepted request and any locally built word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            mem_q   <= 1'b0;
            local_q <= '0;
        end else begin
            valid_q <= take;
            mem_q   <= take & from_mem;
            local_q <= (take & !from_mem) ? local_word : '0;
        end
    end

    // Select the answer source; zero when idle.
    always_comb begin
        rsp_valid = valid_q;
        if (!valid_q)
            rsp_data = '0;
        else if (mem_q)
            rsp_data = mem_word_rev;
        else
            rsp_data = local_q;
    end

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_data == '0));
endmodule

// File: rtl/ld_front.sv
// Module: ld_front
// Load front end: block-crossing check, console receive window at two
// fixed addresses, and a byte-reversed path to a one-cycle-latency memory.
// Assumes one request per cycle at most and that the memory returns data
// exactly one cycle after mem_rd_en.
module ld_front
    import ld_front_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int BLOCK_LG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fault,
    output logic              rx_clear,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic              crosses;
    logic              legal;
    logic              hit_data;
    logic              hit_stat;
    logic [DATA_W-1:0] con_word;
    logic [DATA_W-1:0] mem_rev;

    ld_block_check #(.ADDR_W(ADDR_W), .BLOCK_LG2(BLOCK_LG2)) i_chk (
        .addr    (req_addr),
        .size    (req_size),
        .crosses (crosses)
    );

    ld_byte_rev #(.DATA_W(DATA_W)) i_rev (
        .din  (mem_rdata),
        .dout (mem_rev)
    );

    // Decode the request: fault, console hits, memory strobe.
    always_comb begin
        fault     = req_valid & crosses;
        legal     = req_valid & !crosses;
        hit_data  = (req_addr == ADDR_W'(CON_DATA_ADDR));
        hit_stat  = (req_addr == ADDR_W'(CON_STAT_ADDR));
        rx_clear  = legal & hit_data;
        mem_rd_en = legal & !hit_data & !hit_stat;
        mem_addr  = req_addr;
    end

    // Build the console word for whichever console address was hit.
    always_comb begin
        con_word = '0;
        if (hit_data) begin
            con_word[CON_BYTE_LSB +: 8] = rx_byte;
            con_word[CON_FLAG_BIT]      = rx_valid;
        end else if (hit_stat) begin
            con_word = DATA_W'(CON_STAT_WORD);
        end
    end

    ld_resp_stage #(.DATA_W(DATA_W)) i_rsp (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (legal),
        .from_mem     (mem_rd_en),
        .local_word   (con_word),
        .mem_word_rev (mem_rev),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data)
    );

    p_fault_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_rd_en && !rx_clear));

    p_fault_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !rsp_valid);

    p_byte_never_faults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |-> !fault);

    p_mem_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> rsp_valid);

    p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !fault) |=> !rsp_valid);

    p_console_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr == ADDR_W'(CON_DATA_ADDR) ||
                       req_addr == ADDR_W'(CON_STAT_ADDR))) |-> !mem_rd_en);

    p_clear_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear |=> (rsp_valid &&
                      rsp_data[CON_BYTE_LSB +: 8] == $past(rx_byte) &&
                      rsp_data[CON_FLAG_BIT] == $past(rx_valid)));
endmodule

// File: tb/test_ld_front.sv
// Bench for ld_front: a vector table walked by one loop, then directed
// tests for reset, back-to-back reads and reset during a request.
module test_ld_front;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;

    // kind: 0 = memory, 1 = console data word, 2 = status word
    localparam logic [63:0] V_ADDR [NVEC] = '{
        64'h1000, 64'h1008, 64'h1009, 64'h100F,
        64'h100F, 64'h100E, 64'h100C, 64'h100D,
        64'h7F00_0000, 64'h7F00_0000, 64'h7F00_0004, 64'h7F00_0008,
        64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFF9, 64'h7F00_0001, 64'h7F00_000C
    };
    localparam logic [1:0] V_SIZE [NVEC] = '{
        2'd3, 2'd3, 2'd3, 2'd0,
        2'd1, 2'd1, 2'd2, 2'd2,
        2'd2, 2'd3, 2'd3, 2'd3,
        2'd3, 2'd3, 2'd0, 2'd3
    };
    localparam logic [7:0] V_RXB [NVEC] = '{
        8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88,
        8'hA5, 8'h3C, 8'h99, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE
    };
    localparam logic V_RXV [NVEC] = '{
        1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
        1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1
    };
    localparam logic V_FAULT [NVEC] = '{
        1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1
    };
    localparam int V_KIND [NVEC] = '{
        0, 0, 0, 0, 0, 0, 0, 0,
        1, 1, 2, 0, 0, 0, 0, 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [63:0] mem_rdata;
    logic        fault, rx_clear, mem_rd_en, rsp_valid;
    logic [63:0] mem_addr, rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ld_front i_ld_front (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .mem_rdata(mem_rdata), .fault(fault), .rx_clear(rx_clear),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    function automatic logic [63:0] mem_pattern(input logic [63:0] a);
        return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    function automatic logic [63:0] reversed(input logic [63:0] d);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = d[8*(7-k) +: 8];
        return r;
    endfunction

    // Memory model: one-cycle read latency.
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_pattern(mem_addr);
        else           mem_rdata <= 64'hDEAD_BEEF_DEAD_BEEF;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expected_word(input int idx);
        case (V_KIND[idx])
            1:       return {32'h0, V_RXB[idx], V_RXV[idx], 23'h0};
            2:       return 64'h0000_0000_0004_FFFF;
            default: return reversed(mem_pattern(V_ADDR[idx]));
        endcase
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R9 reset rsp_data", rsp_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle rsp_valid", 64'(rsp_valid), 64'd0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            req_valid = 1'b1;
            req_addr  = V_ADDR[i];
            req_size  = V_SIZE[i];
            rx_byte   = V_RXB[i];
            rx_valid  = V_RXV[i];
            #1;
            check($sformatf("R1 fault vec %0d", i), 64'(fault), 64'(V_FAULT[i]));
            check($sformatf("R3 mem_rd_en vec %0d", i), 64'(mem_rd_en),
                  64'(!V_FAULT[i] && V_KIND[i] == 0));
            check($sformatf("R6 rx_clear vec %0d", i), 64'(rx_clear),
                  64'(!V_FAULT[i] && V_KIND[i] == 1));
            if (mem_rd_en) check($sformatf("R3 mem_addr vec %0d", i), mem_addr, V_ADDR[i]);
            @(negedge clk);
            req_valid = 1'b0;
            rx_byte   = 8'h00;
            rx_valid  = 1'b0;
            #1;
            check($sformatf("R2 rsp_valid vec %0d", i), 64'(rsp_valid), 64'(!V_FAULT[i]));
            check($sformatf("R4 R5 R7 rsp_data vec %0d", i), rsp_data,
                  V_FAULT[i] ? 64'd0 : expected_word(i));
            @(negedge clk);
        end

        // Back-to-back: memory then console data then status (R3 R4 R5 R7)
        req_valid = 1'b1; req_addr = 64'h2000; req_size = 2'd3;
        @(negedge clk);
        req_addr = 64'h7F00_0000; req_size = 2'd0; rx_byte = 8'h5A; rx_valid = 1'b1;
        #1;
        check("R3 b2b rsp_valid 1", 64'(rsp_valid), 64'd1);
        check("R4 b2b mem data", rsp_data, reversed(mem_pattern(64'h2000)));
        check("R6 b2b rx_clear", 64'(rx_clear), 64'd1);
        @(negedge clk);
        req_addr = 64'h7F00_0004; req_size = 2'd2; rx_byte = 8'h00; rx_valid = 1'b0;
        #1;
        check("R5 b2b console word", rsp_data, 64'h0000_0000_5A80_0000);
        check("R6 b2b no clear on status", 64'(rx_clear), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R7 b2b status word", rsp_data, 64'h0000_0000_0004_FFFF);
        @(negedge clk);
        check("R9 idle after b2b", rsp_data, 64'd0);

        // Reset during a request drops the response (R9)
        req_valid = 1'b1; req_addr = 64'h3000; req_size = 2'd3; rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b1;
        #1;
        check("R9 reset drops response", 64'(rsp_valid), 64'd0);
        check("R9 reset zero data", rsp_data, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule